// File: doc/BRIEF.md
# Saturating Integer Width Converter

This unit takes one 32-bit register operand and produces a result of another integer width: 8, 16 or 32 bits. First it picks a byte-aligned field of the operand and widens it to 32 bits, with sign fill or zero fill. It can then take the absolute value of the widened value, negate it, or do both. Last, it either keeps only the low bits of the destination width or clamps the value into that width's range. The clamp bounds depend on whether the source and the destination are signed.

The conversion is computed combinationally from the inputs and captured in an output register at each rising clock edge. Some width and selector combinations are not allowed. For those the unit raises an illegal flag and keeps the previous result instead of converting.

Width codes on `src_w_i` and `dst_w_i`: 0 is byte (8 bits), 1 is short (16 bits), 2 is word (32 bits), and 3 is reserved.

Top module: `sat_int_conv`

## Requirements
- R1: While `rst_n` is low, and after it rises, `result_o` reads 0 and `illegal_o` reads 0 until the first conversion is captured.
- R2: The source field starts at bit `byte_sel_i*8` of the operand. It is 8, 16 or 32 bits long for width code 0, 1 or 2. It is sign-extended to 32 bits when `src_sgn_i` is 1 and zero-extended when it is 0.
- R3: The combination is illegal when any of these holds: a width code is 3; the source code is 1 and `byte_sel_i` is 1 or 3; the source code is 2 and `byte_sel_i` is not 0. On the next edge `illegal_o` goes to 1 and `result_o` keeps its previous value.
- R4: When `abs_i` is set, the absolute value is taken first. When `neg_i` is set, the value is then negated. Both use 32-bit two's-complement wraparound, so the absolute value of 0x80000000 stays 0x80000000.
- R5: With `sat_i` at 0, the result is the low 8, 16 or 32 bits of the processed value, zero-extended to 32 bits.
- R6: With `sat_i` at 1 and both sides signed, the value is clamped as a signed number to [-128,127], [-32768,32767] or [0x80000000,0x7FFFFFFF]. The result is sign-extended to 32 bits, so -128 reads 0xFFFFFF80.
- R7: With `sat_i` at 1, a signed destination and an unsigned source, the value is clamped as an unsigned number to [0,0x7F], [0,0x7FFF] or [0,0x7FFFFFFF].
- R8: With `sat_i` at 1 and an unsigned destination, a signed source whose processed value is negative becomes 0 first. The value is then clamped as an unsigned number to [0,0xFF], [0,0xFFFF] or [0,0xFFFFFFFF].
- R9: A legal conversion appears on `result_o` one clock edge after its inputs are applied, with `illegal_o` at 0. The outputs do not change before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| operand_i | input | 32 | Source register value |
| byte_sel_i | input | 2 | Byte lane where the source field starts |
| src_w_i | input | 2 | Source width code |
| dst_w_i | input | 2 | Destination width code |
| src_sgn_i | input | 1 | Source is signed |
| dst_sgn_i | input | 1 | Destination is signed |
| abs_i | input | 1 | Take the absolute value |
| neg_i | input | 1 | Negate after the absolute value |
| sat_i | input | 1 | Saturate instead of truncating |
| result_o | output | 32 | Registered conversion result |
| illegal_o | output | 1 | Registered illegal-combination flag |

## Verification
Random operands are mixed with boundary patterns placed in every byte lane. The boundary patterns are 0, ±1, and each width's signed and unsigned extremes.
- With the boundary patterns, an off-by-one in a clamp bound shows up, and so does a confusion between signed and unsigned comparison.
- Sweeping all four signedness pairs with saturation on and off separates the four result paths. It also shows whether the negative-to-zero step is taken only for a signed source.
- Values placed on 0x80000000 and 0xFF80 under abs and neg show the order of the two operations and the 32-bit wraparound.
- Reserved codes and misaligned short or word selectors check that the output register holds its value rather than loading a converted one.

// File: rtl/sic_pkg.sv
package sic_pkg;
  localparam int XW = 32;
  localparam int LANE_W = 8;

  typedef enum logic [1:0] {
    WID_B = 2'd0,
    WID_H = 2'd1,
    WID_W = 2'd2,
    WID_X = 2'd3
  } wid_e;

  // mask of the low bits kept by a width code
  function automatic logic [XW-1:0] low_mask(wid_e w);
    case (w)
      WID_B:   return {{(XW-8){1'b0}}, 8'hFF};
      WID_H:   return {{(XW-16){1'b0}}, 16'hFFFF};
      WID_W:   return {XW{1'b1}};
      default: return '0;
    endcase
  endfunction

  function automatic logic [XW-1:0] smax_of(wid_e w);
    return low_mask(w) >> 1;
  endfunction

  function automatic logic [XW-1:0] smin_of(wid_e w);
    return ~smax_of(w);
  endfunction

  function automatic logic [XW-1:0] trunc_to(logic [XW-1:0] v, wid_e w);
    return v & low_mask(w);
  endfunction

  // signed source, signed destination
  function automatic logic [XW-1:0] clamp_ss(logic [XW-1:0] v, wid_e w);
    if ($signed(v) > $signed(smax_of(w))) return smax_of(w);
    if ($signed(v) < $signed(smin_of(w))) return smin_of(w);
    return v;
  endfunction

  // unsigned source, signed destination
  function automatic logic [XW-1:0] clamp_us(logic [XW-1:0] v, wid_e w);
    return (v > smax_of(w)) ? smax_of(w) : v;
  endfunction

  // any source, unsigned destination
  function automatic logic [XW-1:0] clamp_xu(logic [XW-1:0] v, wid_e w, logic src_sgn);
    logic [XW-1:0] t;
    t = (src_sgn && v[XW-1]) ? '0 : v;
    return (t > low_mask(w)) ? low_mask(w) : t;
  endfunction

  function automatic logic [XW-1:0] abs_then_neg(logic [XW-1:0] v, logic a, logic n);
    logic [XW-1:0] t;
    t = (a && v[XW-1]) ? (~v + 1'b1) : v;
    return n ? (~t + 1'b1) : t;
  endfunction
endpackage

// File: rtl/cvt_field_pick.sv
module cvt_field_pick
  import sic_pkg::*;
#(
  parameter int W     = XW,
  parameter int LW    = LANE_W,
  localparam int LANES = W / LW,
  localparam int SW    = $clog2(LANES)
) (
  input  logic [W-1:0]  operand_i,
  input  logic [SW-1:0] sel_i,
  input  wid_e          src_w_i,
  input  logic          sgn_i,
  output logic [W-1:0]  field_o,
  output logic          bad_o
);
  logic [W-1:0] lane_sh [LANES];
  logic [W-1:0] sh;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_sh[g] = operand_i >> (g * LW);
  end

  assign sh = lane_sh[sel_i];

  always_comb begin
    case (src_w_i)
      WID_B:   field_o = {{(W-8){sgn_i & sh[7]}}, sh[7:0]};
      WID_H:   field_o = {{(W-16){sgn_i & sh[15]}}, sh[15:0]};
      default: field_o = sh;
    endcase
  end

  // misaligned short or word field, or reserved source code
  assign bad_o = (src_w_i == WID_X) ||
                 ((src_w_i == WID_H) && sel_i[0]) ||
                 ((src_w_i == WID_W) && (sel_i != '0));
endmodule

// File: rtl/cvt_sign_ops.sv
module cvt_sign_ops
  import sic_pkg::*;
#(
  parameter int W = XW
) (
  input  logic [W-1:0] val_i,
  input  logic         abs_i,
  input  logic         neg_i,
  output logic [W-1:0] val_o
);
  assign val_o = abs_then_neg(val_i, abs_i, neg_i);
endmodule

// File: rtl/cvt_range_fit.sv
module cvt_range_fit
  import sic_pkg::*;
#(
  parameter int W = XW
) (
  input  logic [W-1:0] val_i,
  input  wid_e         dst_w_i,
  input  logic         src_sgn_i,
  input  logic         dst_sgn_i,
  input  logic         sat_i,
  output logic [W-1:0] res_o
);
  always_comb begin
    if (!sat_i)                       res_o = trunc_to(val_i, dst_w_i);
    else if (src_sgn_i && dst_sgn_i)  res_o = clamp_ss(val_i, dst_w_i);
    else if (dst_sgn_i)               res_o = clamp_us(val_i, dst_w_i);
    else                              res_o = clamp_xu(val_i, dst_w_i, src_sgn_i);
  end
endmodule

// File: rtl/sat_int_conv.sv
module sat_int_conv
  import sic_pkg::*;
#(
  parameter int W  = XW,
  parameter int LW = LANE_W,
  localparam int SW = $clog2(W / LW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  operand_i,
  input  logic [SW-1:0] byte_sel_i,
  input  logic [1:0]    src_w_i,
  input  logic [1:0]    dst_w_i,
  input  logic          src_sgn_i,
  input  logic          dst_sgn_i,
  input  logic          abs_i,
  input  logic          neg_i,
  input  logic          sat_i,
  output logic [W-1:0]  result_o,
  output logic          illegal_o
);
  wid_e         src_w, dst_w;
  logic [W-1:0] field_w, proc_w, fit_w;
  logic         src_bad_w, legal_w;

  assign src_w = wid_e'(src_w_i);
  assign dst_w = wid_e'(dst_w_i);

  cvt_field_pick #(.W(W), .LW(LW)) u_pick (
    .operand_i (operand_i),
    .sel_i     (byte_sel_i),
    .src_w_i   (src_w),
    .sgn_i     (src_sgn_i),
    .field_o   (field_w),
    .bad_o     (src_bad_w)
  );

  cvt_sign_ops #(.W(W)) u_sign (
    .val_i (field_w),
    .abs_i (abs_i),
    .neg_i (neg_i),
    .val_o (proc_w)
  );

  cvt_range_fit #(.W(W)) u_fit (
    .val_i     (proc_w),
    .dst_w_i   (dst_w),
    .src_sgn_i (src_sgn_i),
    .dst_sgn_i (dst_sgn_i),
    .sat_i     (sat_i),
    .res_o     (fit_w)
  );

  assign legal_w = !src_bad_w && (dst_w != WID_X);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_o  <= '0;
      illegal_o <= 1'b0;
    end else begin
      illegal_o <= !legal_w;
      if (legal_w) result_o <= fit_w;
    end
  end

  // R3: an illegal combination keeps the old result and raises the flag
  a_r3_hold_on_illegal: assert property (@(posedge clk) disable iff (!rst_n)
    !legal_w |=> ($stable(result_o) && illegal_o));

  // R9: a legal combination clears the flag one edge later
  a_r9_legal_clears: assert property (@(posedge clk) disable iff (!rst_n)
    legal_w |=> !illegal_o);

  // R4: absolute value alone never yields a negative word except the minimum
  a_r4_abs_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
    (abs_i && !neg_i && (field_w != {1'b1, {(W-1){1'b0}}})) |-> !proc_w[W-1]);

  // R5: truncation to a byte leaves the upper bits clear
  a_r5_trunc_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (legal_w && !sat_i && (dst_w == WID_B)) |=> (result_o[W-1:8] == '0));

  // R6: signed byte saturation is a sign-extended 8-bit value
  a_r6_ss_byte_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (legal_w && sat_i && src_sgn_i && dst_sgn_i && (dst_w == WID_B))
      |=> ((result_o[W-1:7] == '0) || (result_o[W-1:7] == '1)));

  // R8: a negative signed source saturates to zero for an unsigned destination
  a_r8_neg_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (legal_w && sat_i && src_sgn_i && !dst_sgn_i && proc_w[W-1]) |=> (result_o == '0));
endmodule

// File: tb/sat_int_conv_tb.sv
module sat_int_conv_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] operand_i = '0;
  logic [1:0]  byte_sel_i = '0, src_w_i = '0, dst_w_i = '0;
  logic        src_sgn_i = 0, dst_sgn_i = 0, abs_i = 0, neg_i = 0, sat_i = 0;
  logic [31:0] result_o;
  logic        illegal_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] exp_res = '0;

  always #(CLK_P/2) clk = ~clk;

  sat_int_conv u_dut (
    .clk(clk), .rst_n(rst_n), .operand_i(operand_i), .byte_sel_i(byte_sel_i),
    .src_w_i(src_w_i), .dst_w_i(dst_w_i), .src_sgn_i(src_sgn_i), .dst_sgn_i(dst_sgn_i),
    .abs_i(abs_i), .neg_i(neg_i), .sat_i(sat_i), .result_o(result_o), .illegal_o(illegal_o)
  );

  function automatic int wbits(logic [1:0] c);
    return (c == 2'd0) ? 8 : (c == 2'd1) ? 16 : 32;
  endfunction

  function automatic longint as_s32(longint x);
    return (x >= 64'sh8000_0000) ? x - 64'sh1_0000_0000 : x;
  endfunction

  // reference model in 64-bit integer arithmetic: {illegal, result}
  function automatic logic [32:0] ref_conv(logic [31:0] op, logic [1:0] sel, logic [1:0] sw,
      logic [1:0] dw, bit ss, bit ds, bit ab, bit ng, bit st);
    longint f, x, sx, lo, hi, y;
    int len, dl;
    if (sw == 3 || dw == 3 || (sw == 1 && (sel == 1 || sel == 3)) || (sw == 2 && sel != 0))
      return {1'b1, 32'h0};
    len = wbits(sw);
    dl  = wbits(dw);
    f = (longint'(op) >> (sel * 8)) % (longint'(1) << len);
    if (ss && f >= (longint'(1) << (len - 1))) f = f - (longint'(1) << len);
    x = f & 64'hFFFF_FFFF;
    if (ab && as_s32(x) < 0) x = (-as_s32(x)) & 64'hFFFF_FFFF;
    if (ng) x = (64'sh1_0000_0000 - x) & 64'hFFFF_FFFF;
    sx = as_s32(x);
    if (!st) y = x % (longint'(1) << dl);
    else if (ss && ds) begin
      lo = -(longint'(1) << (dl - 1));
      hi = (longint'(1) << (dl - 1)) - 1;
      y = (sx > hi) ? hi : (sx < lo) ? lo : sx;
      y = y & 64'hFFFF_FFFF;
    end else if (ds) begin
      hi = (longint'(1) << (dl - 1)) - 1;
      y = (x > hi) ? hi : x;
    end else begin
      hi = (longint'(1) << dl) - 1;
      y = (ss && sx < 0) ? 0 : x;
      if (y > hi) y = hi;
    end
    return {1'b0, y[31:0]};
  endfunction

  task automatic check(string tag, logic [31:0] gr, logic gi, logic [31:0] er, logic ei);
    n_chk++;
    if (gr !== er || gi !== ei) begin
      n_bad++;
      $display("FAIL %s: result=%h illegal=%b expected result=%h illegal=%b", tag, gr, gi, er, ei);
    end
  endtask

  task automatic apply(logic [31:0] op, logic [1:0] sel, logic [1:0] sw, logic [1:0] dw,
      bit ss, bit ds, bit ab, bit ng, bit st, string tag);
    logic [32:0] m;
    @(negedge clk);
    operand_i = op; byte_sel_i = sel; src_w_i = sw; dst_w_i = dw;
    src_sgn_i = ss; dst_sgn_i = ds; abs_i = ab; neg_i = ng; sat_i = st;
    m = ref_conv(op, sel, sw, dw, ss, ds, ab, ng, st);
    if (!m[32]) exp_res = m[31:0];
    @(posedge clk);
    @(negedge clk);
    check(tag, result_o, illegal_o, exp_res, m[32]);
  endtask

  function automatic string auto_tag(logic [32:0] m, bit ss, bit ds, bit st);
    if (m[32]) return "R3";
    if (!st) return "R5";
    if (ss && ds) return "R6";
    if (ds) return "R7";
    return "R8";
  endfunction

  function automatic logic [31:0] pick_op();
    logic [31:0] edges [13] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7F, 32'h80, 32'hFF,
      32'h7FFF, 32'h8000, 32'hFFFF, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FF80, 32'hFFFF_8000};
    if ($urandom_range(0, 3) == 0)
      return edges[$urandom_range(0, 12)] << (8 * $urandom_range(0, 3));
    return $urandom();
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: result=%h illegal=%b expected completion", result_o, illegal_o);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check("R1 in reset", result_o, illegal_o, 32'h0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", result_o, illegal_o, 32'h0, 1'b0);

    // R2: field selection and extension
    apply(32'h8A7F_C312, 2'd2, 2'd0, 2'd2, 1, 0, 0, 0, 0, "R2 signed byte lane2");
    apply(32'h8A7F_C312, 2'd3, 2'd0, 2'd2, 0, 0, 0, 0, 0, "R2 unsigned byte lane3");
    apply(32'h8A7F_C312, 2'd2, 2'd1, 2'd2, 1, 0, 0, 0, 0, "R2 signed short hi");
    // R4: order and wraparound
    apply(32'h8000_0000, 2'd0, 2'd2, 2'd2, 1, 1, 1, 0, 0, "R4 abs of min");
    apply(32'h0000_FF80, 2'd0, 2'd0, 2'd2, 1, 1, 1, 1, 0, "R4 abs then neg");
    // R6/R7/R8 bounds
    apply(32'h0000_0080, 2'd0, 2'd1, 2'd0, 1, 1, 0, 0, 1, "R6 short to byte high");
    apply(32'h0000_8000, 2'd0, 2'd1, 2'd0, 1, 1, 0, 0, 1, "R6 short to byte low");
    apply(32'h0000_00FF, 2'd0, 2'd0, 2'd0, 0, 1, 0, 0, 1, "R7 unsigned byte to signed");
    apply(32'h0000_FFFF, 2'd0, 2'd1, 2'd1, 1, 0, 0, 0, 1, "R8 negative to zero");
    apply(32'h0001_0000, 2'd0, 2'd2, 2'd1, 0, 0, 0, 0, 1, "R8 unsigned cap");
    // R3: illegal combinations hold the result
    apply(32'h1234_5678, 2'd1, 2'd1, 2'd0, 0, 0, 0, 0, 0, "R3 short sel1");
    apply(32'h1234_5678, 2'd0, 2'd0, 2'd3, 0, 0, 0, 0, 0, "R3 reserved dst");
    apply(32'h1234_5678, 2'd2, 2'd2, 2'd2, 0, 0, 0, 0, 0, "R3 word sel2");

    // R9: no change before the capturing edge
    apply(32'h0000_0011, 2'd0, 2'd0, 2'd0, 0, 0, 0, 0, 0, "R9 preload");
    @(negedge clk);
    operand_i = 32'h0000_0022;
    #(CLK_P/2 - 1);
    check("R9 before edge", result_o, illegal_o, 32'h11, 1'b0);
    @(posedge clk);
    @(negedge clk);
    check("R9 after edge", result_o, illegal_o, 32'h22, 1'b0);
    exp_res = 32'h22;

    for (int i = 0; i < 4000; i++) begin
      logic [31:0] op;
      logic [1:0] sel, sw, dw;
      bit ss, ds, ab, ng, st;
      op  = pick_op();
      sel = 2'($urandom_range(0, 3));
      sw  = ($urandom_range(0, 15) == 0) ? 2'd3 : 2'($urandom_range(0, 2));
      dw  = ($urandom_range(0, 15) == 0) ? 2'd3 : 2'($urandom_range(0, 2));
      if (sw == 2 && $urandom_range(0, 3) != 0) sel = 2'd0;
      ss = 1'($urandom()); ds = 1'($urandom());
      ab = ($urandom_range(0, 3) == 0); ng = ($urandom_range(0, 3) == 0);
      st = 1'($urandom());
      apply(op, sel, sw, dw, ss, ds, ab, ng, st,
            auto_tag(ref_conv(op, sel, sw, dw, ss, ds, ab, ng, st), ss, ds, st));
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule